// File: doc/BRIEF.md
# Flash Write and Erase Sequencer

This block is the write half of a serial flash model. An upstream command decoder hands it a decoded opcode with its 24-bit address, then the data bytes that follow, and finally a one-cycle pulse marking the rising edge of chip select. Program commands collect their data in a one-page buffer. Both program and erase commands stay pending until the chip-select pulse. That pulse launches a self-timed operation against an internal byte array. The array can only lose bits when programmed and regains them only when erased.

While an operation runs, `busy` is high. The busy time of each operation kind is its own parameter, counted in system clocks. A write-protect input shields the top eighth of the array from every program and erase. The array is visible through a combinational read port so that a read path, or a bench, can see the result.

The page size, the block sizes and the array size are parameters. The defaults are kept small: 16-byte pages, small blocks of 8 pages, large blocks of 16 pages, and a 512-byte array. Address bits above the array width are ignored.

Top module: `flash_wr_seq`

## Requirements
- R1: Opcode 02h selects byte program, 11h page program, 82h page program with auto-erase, 81h page erase, 50h small-block erase and 20h large-block erase. Any other opcode leaves nothing pending, and a chip-select pulse that follows it starts nothing.
- R2: Page program fills a buffer that starts as all FFh. Filling begins at the page offset `cmd_addr[OFS_W-1:0]` and advances one byte per `data_valid`, wrapping from the last offset back to 0. Buffer bytes that receive no data leave their array bytes unchanged.
- R3: Byte program alters only the byte at its full address, and it uses only the last data byte delivered before the chip-select pulse.
- R4: Programming stores old AND data into each byte, so a program can clear bits but never set them.
- R5: An operation starts only on a `cs_rise` pulse while a valid command is pending. `busy` rises on the next clock and stays high for exactly the parameter cycles of that operation kind: T_BYTE, T_PAGE, T_AUTO, T_PGERASE, T_SBE or T_LBE.
- R6: Page erase ignores the low OFS_W address bits. Small-block erase ignores the low OFS_W+SB_PG_W bits, and large-block erase ignores the low OFS_W+LB_PG_W bits. Every byte in the selected extent reads FFh afterwards, and `cmd_addr` bits at or above ARR_W are ignored.
- R7: Auto-erase first sets the addressed page to FFh and then programs it from the buffer.
- R8: While `wp_n` is 0 at the chip-select pulse, any program or erase whose extent reaches the top eighth of the array (top three address bits all 1) is dropped: `busy` stays 0 and the array is unchanged. Extents below that region still run.
- R9: Commands, data bytes and chip-select pulses that arrive while `busy` is 1 are discarded.
- R10: After reset, `busy` is 0 and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded opcode and address are present |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | 24 | Byte address of the command |
| data_valid | input | 1 | One data byte is present |
| data_byte | input | 8 | Data byte for the page buffer |
| cs_rise | input | 1 | One-cycle pulse at the chip-select rising edge |
| wp_n | input | 1 | Write protect, active low |
| rd_addr | input | ARR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |
| busy | output | 1 | A self-timed operation is running |

## Verification
A table-driven sequence of commands is checked against a reference array. After each command the whole array is compared with that reference.

The sequence mixes several cases. Partial page loads separate the buffer's fill-with-ones start from a stale buffer. A load longer than a page at an unaligned offset tests the offset wrap. A second program over existing data separates AND from overwrite. Repeated byte sends show whether the first byte or the last byte is kept.

Erases are aimed at unaligned addresses, and one address carries nonzero upper bits; both show whether the right address bits are masked. The same commands are repeated with write-protect low and high, on extents that touch the protected eighth and on extents that stay below it. These cases separate correct extent-overlap protection from a check on the start address alone. Directed cases measure busy lengths and send a command while busy.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

    localparam logic [7:0] OPC_BYTE_PROG = 8'h02;
    localparam logic [7:0] OPC_PAGE_PROG = 8'h11;
    localparam logic [7:0] OPC_AUTO_PROG = 8'h82;
    localparam logic [7:0] OPC_PAGE_ERS  = 8'h81;
    localparam logic [7:0] OPC_SBLK_ERS  = 8'h50;
    localparam logic [7:0] OPC_LBLK_ERS  = 8'h20;

    typedef enum logic [2:0] {
        K_NONE, K_BYTE, K_PAGE, K_AUTO, K_PGERASE, K_SBERASE, K_LBERASE
    } op_kind_e;

    typedef enum logic [1:0] {
        S_IDLE, S_ERASE, S_PROG, S_HOLD
    } phase_e;

    function automatic op_kind_e opc_kind(input logic [7:0] opc);
        case (opc)
            OPC_BYTE_PROG: return K_BYTE;
            OPC_PAGE_PROG: return K_PAGE;
            OPC_AUTO_PROG: return K_AUTO;
            OPC_PAGE_ERS:  return K_PGERASE;
            OPC_SBLK_ERS:  return K_SBERASE;
            OPC_LBLK_ERS:  return K_LBERASE;
            default:       return K_NONE;
        endcase
    endfunction

    function automatic logic is_prog(input op_kind_e k);
        return (k == K_BYTE) || (k == K_PAGE) || (k == K_AUTO);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/flash_wr_extent.sv
// Turns an operation kind and address into the mask of ignored address
// bits (the extent) and decides whether write protection blocks it.
module flash_wr_extent
    import flash_wr_pkg::*;
#(
    parameter int ARR_W   = 9,
    parameter int OFS_W   = 4,
    parameter int SB_PG_W = 3,
    parameter int LB_PG_W = 4,
    parameter int PROT_W  = 3
) (
    input  op_kind_e          kind,
    input  logic [ARR_W-1:0]  addr,
    input  logic              wp_n,
    output logic [ARR_W-1:0]  span_mask,
    output logic              blocked
);
    localparam logic [ARR_W-1:0] PAGE_M = ARR_W'((1 << OFS_W) - 1);
    localparam logic [ARR_W-1:0] SBLK_M = ARR_W'((1 << (OFS_W + SB_PG_W)) - 1);
    localparam logic [ARR_W-1:0] LBLK_M = ARR_W'((1 << (OFS_W + LB_PG_W)) - 1);

    logic [ARR_W-1:0] last_a;

    always_comb begin
        case (kind)
            K_PAGE, K_AUTO, K_PGERASE: span_mask = PAGE_M;
            K_SBERASE:                 span_mask = SBLK_M;
            K_LBERASE:                 span_mask = LBLK_M;
            default:                   span_mask = '0;
        endcase
        // protected region sits at the top, so an extent touches it
        // exactly when its highest address does
        last_a  = addr | span_mask;
        blocked = !wp_n && (&last_a[ARR_W-1 -: PROT_W]);
    end
endmodule

// File: rtl/flash_wr_array.sv
// Byte array model: one write port, one user read port, one read port
// aligned with the write address for read-modify-write.
module flash_wr_array #(
    parameter int ARR_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ARR_W-1:0] wa,
    input  logic [7:0]       wd,
    output logic [7:0]       wold,
    input  logic [ARR_W-1:0] ra,
    output logic [7:0]       rd
);
    localparam int ARR_SZ = 1 << ARR_W;

    logic [7:0] mem_q [ARR_SZ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ARR_SZ; i++) mem_q[i] <= 8'hFF;
        end else if (we) begin
            mem_q[wa] <= wd;
        end
    end

    assign wold = mem_q[wa];
    assign rd   = mem_q[ra];
endmodule

// File: rtl/flash_wr_seq.sv
module flash_wr_seq
    import flash_wr_pkg::*;
#(
    parameter int ARR_W     = 9,
    parameter int OFS_W     = 4,
    parameter int SB_PG_W   = 3,
    parameter int LB_PG_W   = 4,
    parameter int PROT_W    = 3,
    parameter int T_BYTE    = 40,
    parameter int T_PAGE    = 60,
    parameter int T_AUTO    = 90,
    parameter int T_PGERASE = 50,
    parameter int T_SBE     = 150,
    parameter int T_LBE     = 300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [23:0]      cmd_addr,
    input  logic             data_valid,
    input  logic [7:0]       data_byte,
    input  logic             cs_rise,
    input  logic             wp_n,
    input  logic [ARR_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic             busy
);
    localparam int PAGE_B = 1 << OFS_W;
    localparam int T_MAX  = imax(imax(imax(T_BYTE, T_PAGE), imax(T_AUTO, T_PGERASE)),
                                 imax(T_SBE, T_LBE));
    localparam int TMR_W  = $clog2(T_MAX + 1);

    typedef struct packed {
        phase_e                  ph;
        op_kind_e                kind;
        logic                    pend;
        logic [ARR_W-1:0]        addr;
        logic [OFS_W-1:0]        ptr;
        logic [ARR_W-1:0]        idx;
        logic [TMR_W-1:0]        tmr;
        logic [PAGE_B-1:0][7:0]  pbuf;
    } st_t;

    st_t st_q, st_d;

    logic [ARR_W-1:0] span_mask;
    logic             blocked;
    logic             mem_we;
    logic [ARR_W-1:0] mem_wa;
    logic [7:0]       mem_wd;
    logic [7:0]       mem_old;
    logic             erasing;

    flash_wr_extent #(
        .ARR_W(ARR_W), .OFS_W(OFS_W), .SB_PG_W(SB_PG_W),
        .LB_PG_W(LB_PG_W), .PROT_W(PROT_W)
    ) u_ext (
        .kind(st_q.kind), .addr(st_q.addr), .wp_n(wp_n),
        .span_mask(span_mask), .blocked(blocked)
    );

    flash_wr_array #(.ARR_W(ARR_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
        .wold(mem_old), .ra(rd_addr), .rd(rd_data)
    );

    function automatic logic [TMR_W-1:0] dur_of(input op_kind_e k);
        case (k)
            K_BYTE:    return TMR_W'(T_BYTE);
            K_PAGE:    return TMR_W'(T_PAGE);
            K_AUTO:    return TMR_W'(T_AUTO);
            K_PGERASE: return TMR_W'(T_PGERASE);
            K_SBERASE: return TMR_W'(T_SBE);
            default:   return TMR_W'(T_LBE);
        endcase
    endfunction

    always_comb begin
        st_d   = st_q;
        mem_wa = (st_q.addr & ~span_mask) | st_q.idx;
        mem_we = 1'b0;
        mem_wd = 8'hFF;

        if (st_q.ph != S_IDLE && st_q.tmr > TMR_W'(1))
            st_d.tmr = st_q.tmr - TMR_W'(1);

        case (st_q.ph)
            S_IDLE: begin
                if (cs_rise) begin
                    st_d.pend = 1'b0;
                    if (st_q.pend && !blocked) begin
                        st_d.idx = '0;
                        st_d.tmr = dur_of(st_q.kind);
                        st_d.ph  = (st_q.kind == K_BYTE || st_q.kind == K_PAGE)
                                   ? S_PROG : S_ERASE;
                    end
                end else if (cmd_valid) begin
                    st_d.kind = opc_kind(cmd_op);
                    st_d.pend = (opc_kind(cmd_op) != K_NONE);
                    st_d.addr = cmd_addr[ARR_W-1:0];
                    st_d.ptr  = cmd_addr[OFS_W-1:0];
                    st_d.pbuf = '1;
                end else if (data_valid && st_q.pend && is_prog(st_q.kind)) begin
                    st_d.pbuf[st_q.ptr] = data_byte;
                    if (st_q.kind != K_BYTE)
                        st_d.ptr = st_q.ptr + OFS_W'(1);
                end
            end
            S_ERASE: begin
                mem_we = 1'b1;
                mem_wd = 8'hFF;
                if (st_q.idx == span_mask) begin
                    st_d.idx = '0;
                    st_d.ph  = (st_q.kind == K_AUTO) ? S_PROG : S_HOLD;
                end else begin
                    st_d.idx = st_q.idx + ARR_W'(1);
                end
            end
            S_PROG: begin
                mem_we = 1'b1;
                mem_wd = mem_old & st_q.pbuf[mem_wa[OFS_W-1:0]];
                if (st_q.idx == span_mask) st_d.ph  = S_HOLD;
                else                       st_d.idx = st_q.idx + ARR_W'(1);
            end
            default: begin
                if (st_q.tmr <= TMR_W'(1)) st_d.ph = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= S_IDLE;
            st_q.kind <= K_NONE;
            st_q.pbuf <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.ph != S_IDLE);
    assign erasing = (st_q.ph == S_ERASE);
endmodule

// File: rtl/flash_wr_seq_chk.sv
module flash_wr_seq_chk #(
    parameter int ARR_W  = 9,
    parameter int PROT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cs_rise,
    input logic             wp_n,
    input logic             mem_we,
    input logic [ARR_W-1:0] mem_wa,
    input logic [7:0]       mem_wd,
    input logic [7:0]       mem_old,
    input logic             erasing
);
    logic wp_at_go_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                wp_at_go_q <= 1'b1;
        else if (cs_rise && !busy) wp_at_go_q <= wp_n;
    end

    AST_START_ON_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));                               // R5
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);                                            // R5
    AST_FALL_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(mem_we));                               // R5
    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !erasing) |-> ((mem_wd & ~mem_old) == 8'h00));      // R4
    AST_WP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (&mem_wa[ARR_W-1 -: PROT_W])) |-> wp_at_go_q);     // R8
endmodule

bind flash_wr_seq flash_wr_seq_chk #(.ARR_W(ARR_W), .PROT_W(PROT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cs_rise(cs_rise), .wp_n(wp_n),
    .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd), .mem_old(mem_old),
    .erasing(erasing)
);

// File: tb/flash_wr_seq_bench.sv
`timescale 1ns/1ps
module flash_wr_seq_bench;
    localparam int ARR_W = 9;
    localparam int ASZ   = 1 << ARR_W;
    localparam int TB_T_BYTE = 40, TB_T_PAGE = 60, TB_T_AUTO = 90;
    localparam int TB_T_PGE  = 50, TB_T_SBE  = 150, TB_T_LBE = 300;

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] addr;
        logic [7:0]  n;
        logic [7:0]  seed;
        logic        wp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{8'h82, 24'h000020, 8'd4,  8'h11, 1'b1},  // R7 R1 auto-erase, short load
        '{8'h02, 24'h000035, 8'd3,  8'h5A, 1'b1},  // R3 last byte only
        '{8'h11, 24'h00002E, 8'd20, 8'hC3, 1'b1},  // R2 wrap, R4 AND over old data
        '{8'h11, 24'h7A0043, 8'd5,  8'h96, 1'b1},  // R6 upper address bits ignored
        '{8'h81, 24'h000027, 8'd0,  8'h00, 1'b1},  // R6 page erase, unaligned
        '{8'h11, 24'h0001C0, 8'd16, 8'h3C, 1'b0},  // R8 blocked program
        '{8'h11, 24'h0001C4, 8'd16, 8'h3C, 1'b1},  // R8 allowed with wp_n high
        '{8'h50, 24'h0001F3, 8'd0,  8'h00, 1'b0},  // R8 blocked erase
        '{8'h11, 24'h000090, 8'd16, 8'h77, 1'b1},  // R2 prepare small block
        '{8'h50, 24'h0000A5, 8'd0,  8'h00, 1'b1},  // R6 small-block erase
        '{8'h11, 24'h000105, 8'd10, 8'hE1, 1'b0},  // R8 below region runs
        '{8'h20, 24'h0001F0, 8'd0,  8'h00, 1'b1},  // R6 large-block erase
        '{8'h03, 24'h000043, 8'd4,  8'h00, 1'b1},  // R1 unknown opcode ignored
        '{8'h20, 24'h0000FF, 8'd0,  8'h00, 1'b0}   // R8 R6 low half with wp_n low
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, data_valid = 1'b0, cs_rise = 1'b0, wp_n = 1'b1;
    logic [7:0] cmd_op = '0, data_byte = '0;
    logic [23:0] cmd_addr = '0;
    logic [ARR_W-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic busy;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] ref_arr [ASZ];

    always #10 clk = ~clk;

    flash_wr_seq #(
        .T_BYTE(TB_T_BYTE), .T_PAGE(TB_T_PAGE), .T_AUTO(TB_T_AUTO),
        .T_PGERASE(TB_T_PGE), .T_SBE(TB_T_SBE), .T_LBE(TB_T_LBE)
    ) u_flash_wr_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .data_valid(data_valid), .data_byte(data_byte),
        .cs_rise(cs_rise), .wp_n(wp_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k);
        return seed + 8'(k * 37);
    endfunction

    task automatic issue(input logic [7:0] op, input logic [23:0] addr,
                         input int n, input logic [7:0] seed, input logic wp);
        @(negedge clk);
        wp_n = wp; cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            data_valid = 1'b1; data_byte = dbyte(seed, k);
            @(negedge clk);
        end
        data_valid = 1'b0;
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy && cnt < 5000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    // reference model built from the requirements
    task automatic ref_apply(input logic [7:0] op, input logic [23:0] addr,
                             input int n, input logic [7:0] seed, input logic wp);
        logic [8:0] a, mask, base, last;
        logic [7:0] b [16];
        logic [3:0] p;
        bit prog, ers;
        a = addr[8:0];
        prog = 1'b0; ers = 1'b0;
        case (op)
            8'h02: begin mask = 9'h000; prog = 1'b1; end
            8'h11: begin mask = 9'h00F; prog = 1'b1; end
            8'h82: begin mask = 9'h00F; prog = 1'b1; ers = 1'b1; end
            8'h81: begin mask = 9'h00F; ers = 1'b1; end
            8'h50: begin mask = 9'h07F; ers = 1'b1; end
            8'h20: begin mask = 9'h0FF; ers = 1'b1; end
            default: return;
        endcase
        last = a | mask;
        if (!wp && last[8:6] == 3'b111) return;
        base = a & ~mask;
        for (int i = 0; i < 16; i++) b[i] = 8'hFF;
        p = a[3:0];
        for (int k = 0; k < n; k++) begin
            if (op == 8'h02) b[a[3:0]] = dbyte(seed, k);
            else begin b[p] = dbyte(seed, k); p = p + 4'd1; end
        end
        if (ers) for (int i = 0; i <= int'(mask); i++) ref_arr[base + 9'(i)] = 8'hFF;
        if (prog) for (int i = 0; i <= int'(mask); i++)
            ref_arr[base + 9'(i)] = ref_arr[base + 9'(i)] & b[(base + 9'(i)) & 9'h00F];
    endtask

    task automatic compare_all(input string tag);
        int bad = 0;
        int fa = 0;
        logic [7:0] fv = '0;
        for (int i = 0; i < ASZ; i++) begin
            rd_addr = 9'(i);
            #1;
            if (rd_data !== ref_arr[i]) begin
                if (bad == 0) begin fa = i; fv = rd_data; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s array byte %0h actual=%0h expected=%0h (%0d bytes differ)",
                     tag, fa, fv, ref_arr[fa], bad);
        end
    endtask

    initial begin
        int cnt;
        for (int i = 0; i < ASZ; i++) ref_arr[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk(busy == 1'b0, "R10 busy after reset", busy, 0);
        compare_all("R10 array all ones after reset");

        for (int v = 0; v < NV; v++) begin
            issue(VEC[v].op, VEC[v].addr, int'(VEC[v].n), VEC[v].seed, VEC[v].wp);
            ref_apply(VEC[v].op, VEC[v].addr, int'(VEC[v].n), VEC[v].seed, VEC[v].wp);
            wait_idle(cnt);
            compare_all($sformatf("R1-R8 vector %0d op %0h", v, VEC[v].op));
        end

        // R8: blocked command never raises busy
        issue(8'h81, 24'h0001D0, 0, 8'h00, 1'b0);
        chk(busy == 1'b0, "R8 busy stays low when blocked", busy, 0);

        // R5: pulse with nothing pending starts nothing
        @(negedge clk); cs_rise = 1'b1;
        @(negedge clk); cs_rise = 1'b0;
        chk(busy == 1'b0, "R5 no start without pending command", busy, 0);

        // R5: busy length for byte program and large-block erase
        issue(8'h02, 24'h000000, 1, 8'h0F, 1'b1);
        ref_apply(8'h02, 24'h000000, 1, 8'h0F, 1'b1);
        wait_idle(cnt);
        chk(cnt == TB_T_BYTE, "R5 byte program busy cycles", cnt, TB_T_BYTE);
        compare_all("R3 byte program result");

        issue(8'h20, 24'h000010, 0, 8'h00, 1'b1);
        ref_apply(8'h20, 24'h000010, 0, 8'h00, 1'b1);
        wait_idle(cnt);
        chk(cnt == TB_T_LBE, "R5 large erase busy cycles", cnt, TB_T_LBE);

        issue(8'h82, 24'h000050, 2, 8'h44, 1'b1);
        ref_apply(8'h82, 24'h000050, 2, 8'h44, 1'b1);
        wait_idle(cnt);
        chk(cnt == TB_T_AUTO, "R5 R7 auto-erase busy cycles", cnt, TB_T_AUTO);
        compare_all("R7 auto-erase result");

        // R9: program sent while an erase runs is dropped
        issue(8'h81, 24'h000000, 0, 8'h00, 1'b1);
        ref_apply(8'h81, 24'h000000, 0, 8'h00, 1'b1);
        chk(busy == 1'b1, "R9 erase running", busy, 1);
        issue(8'h11, 24'h000010, 16, 8'h00, 1'b1);
        wait_idle(cnt);
        compare_all("R9 command while busy discarded");
        @(negedge clk); cs_rise = 1'b1;
        @(negedge clk); cs_rise = 1'b0;
        chk(busy == 1'b0, "R9 no pending command left after busy", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule